// File: doc/BRIEF.md
# Eight-Output Addressable Latch Bank

This block keeps a bank of single-bit storage outputs. A binary select input picks one of them, and a data input supplies the value to write. Two active-low controls choose between four behaviours. In the first, only the selected bit is written. In the second, the selected bit takes the data value and every other bit is cleared. In the third, the whole bank is frozen. In the fourth, the whole bank is cleared.

The block samples its inputs on the rising edge of one system clock. It is the clocked equivalent of a bank of transparent latches, so every output change appears one clock after the inputs that cause it. A synchronous, active-high power-on reset clears the bank. This reset works on its own and does not depend on the mode controls. The bank can serve as a set of control bits written one at a time, or as a registered one-of-N strobe decoder.

Top module: `addr_latch_bank`

## Requirements
- R1: With `wr_en_n`=0 and `clr_n`=1 sampled at an edge, output `q[sel]` takes `din` after that edge, and every other output keeps its value.
- R2: With `wr_en_n`=0 and `clr_n`=0 sampled at an edge, `q[sel]` takes `din` after that edge, and every other output becomes 0.
- R3: With `wr_en_n`=1 and `clr_n`=1 sampled at an edge, no output changes, whatever the values of `din` and `sel`.
- R4: With `wr_en_n`=1 and `clr_n`=0 sampled at an edge, every output becomes 0.
- R5: `sel` is an unsigned binary number whose most significant bit is bit SEL_W-1. Value k addresses output bit `q[k]`, for k from 0 to 2**SEL_W-1.
- R6: `rst`=1 sampled at an edge clears every output, whatever the mode inputs are.
- R7: In the single-bit write mode, after `sel` moves to a new address, the previously addressed output keeps the value written on the last edge at which it was selected.
- R8: When the block goes from the clear-others write mode to the frozen mode, the outputs keep the pattern from the last edge in write mode. That pattern has at most one bit set.
- R9: After `wr_en_n` returns high with `clr_n`=1, the bank holds the `sel` and `din` values that were sampled on the last edge with `wr_en_n`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high power-on reset |
| sel | input | SEL_W | Binary address of the target output |
| din | input | 1 | Data value written to the addressed output |
| wr_en_n | input | 1 | Active-low write enable |
| clr_n | input | 1 | Active-low bank clear / clear-others control |
| q | output | 2**SEL_W | Stored output bits |

## Verification
The bench builds the block with the default SEL_W of 3, which gives eight outputs. That bank is small enough to visit every address in every mode with both data values, and to compare every output bit on every clock against a behavioural table model. At this width the corner sequences are short to write out: an address change in the middle of a write burst, a move from the clear-others mode into the frozen mode, and a reset asserted during a write.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

    // Operating behaviour chosen by the two active-low controls
    typedef enum logic [1:0] {
        MD_WRITE_ONE  = 2'd0,  // write addressed bit, keep the rest
        MD_WRITE_EXCL = 2'd1,  // write addressed bit, clear the rest
        MD_FREEZE     = 2'd2,  // keep every bit
        MD_WIPE       = 2'd3   // clear every bit
    } al_mode_e;

    // Sampled request presented to the storage array
    typedef struct packed {
        al_mode_e mode;
        logic     din;
    } al_req_t;

    function automatic al_mode_e mode_from_pins(input logic wr_en_n, input logic clr_n);
        al_mode_e m;
        case ({wr_en_n, clr_n})
            2'b01:   m = MD_WRITE_ONE;
            2'b00:   m = MD_WRITE_EXCL;
            2'b11:   m = MD_FREEZE;
            default: m = MD_WIPE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/al_mode_dec.sv
module al_mode_dec
    import addr_latch_pkg::*;
(
    input  logic    wr_en_n,
    input  logic    clr_n,
    input  logic    din,
    output al_req_t req
);
    always_comb begin
        req.mode = mode_from_pins(wr_en_n, clr_n);
        req.din  = din;
    end
endmodule

// File: rtl/al_sel_dec.sv
module al_sel_dec #(
    parameter int SEL_W = 3,
    localparam int N    = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    output logic [N-1:0]     hit
);
    for (genvar k = 0; k < N; k++) begin : g_hit
        assign hit[k] = (sel == SEL_W'(k));
    end
endmodule

// File: rtl/al_store.sv
module al_store
    import addr_latch_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  al_req_t      req,
    input  logic [N-1:0] hit,
    output logic [N-1:0] q
);
    for (genvar k = 0; k < N; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                q[k] <= 1'b0;
            end else begin
                unique case (req.mode)
                    MD_WRITE_ONE:  if (hit[k]) q[k] <= req.din;
                    MD_WRITE_EXCL: q[k] <= hit[k] & req.din;
                    MD_FREEZE:     q[k] <= q[k];
                    MD_WIPE:       q[k] <= 1'b0;
                endcase
            end
        end
    end

    // R3: frozen mode leaves every bit untouched
    p_freeze_stable_r3: assert property (@(posedge clk) disable iff (rst)
        req.mode == MD_FREEZE |=> $stable(q));

    // R4: wipe mode empties the bank
    p_wipe_zero_r4: assert property (@(posedge clk) disable iff (rst)
        req.mode == MD_WIPE |=> q == '0);

    // R2: clear-others mode leaves at most one bit set
    p_excl_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        req.mode == MD_WRITE_EXCL |=> $onehot0(q));
endmodule

// File: rtl/addr_latch_bank.sv
module addr_latch_bank
    import addr_latch_pkg::*;
#(
    parameter int SEL_W = 3,
    localparam int N    = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic             din,
    input  logic             wr_en_n,
    input  logic             clr_n,
    output logic [N-1:0]     q
);
    al_req_t      req;
    logic [N-1:0] hit;

    al_mode_dec u_mode (
        .wr_en_n (wr_en_n),
        .clr_n   (clr_n),
        .din     (din),
        .req     (req)
    );

    al_sel_dec #(.SEL_W(SEL_W)) u_sel (
        .sel (sel),
        .hit (hit)
    );

    al_store #(.N(N)) u_store (
        .clk (clk),
        .rst (rst),
        .req (req),
        .hit (hit),
        .q   (q)
    );

    // R1/R5: the addressed bit takes the data in single-bit write mode
    p_write_target_r1: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_n && clr_n) |=> q[$past(sel)] == $past(din));

    // R1/R7: single-bit write changes at most one bit
    p_write_single_r1: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_n && clr_n) |=> $countones(q ^ $past(q)) <= 1);

    // R2: addressed bit follows data in clear-others mode
    p_excl_target_r2: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_n && !clr_n) |=> q[$past(sel)] == $past(din));

    // R6: power-on reset clears the bank
    p_reset_clear_r6: assert property (@(posedge clk)
        rst |=> q == '0);
endmodule

// File: tb/addr_latch_bank_tb.sv
module addr_latch_bank_tb_top;
    localparam int SEL_W = 3;
    localparam int N     = 1 << SEL_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [SEL_W-1:0] sel = '0;
    logic             din = 1'b0;
    logic             wr_en_n = 1'b1;
    logic             clr_n = 1'b1;
    logic [N-1:0]     q;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    bit [N-1:0] model = '0;

    always #2 clk = ~clk;  // 250 MHz

    addr_latch_bank #(.SEL_W(SEL_W)) dut_i (
        .clk(clk), .rst(rst), .sel(sel), .din(din),
        .wr_en_n(wr_en_n), .clr_n(clr_n), .q(q)
    );

    // Behavioural reference following the four-row mode table
    function automatic bit [N-1:0] ref_next(bit [N-1:0] cur, bit r, bit e_n, bit c_n,
                                           int a, bit d);
        bit [N-1:0] nx = cur;
        if (r) return '0;
        if (!e_n && c_n)       nx[a] = d;
        else if (!e_n && !c_n) begin nx = '0; nx[a] = d; end
        else if (e_n && !c_n)  nx = '0;
        return nx;
    endfunction

    task automatic check(string tag);
        n_run++;
        if (q !== model) begin
            n_fail++;
            $display("FAIL %s: q=%b expected %b", tag, q, model);
        end
    endtask

    // Drive on the falling edge, let one rising edge pass, compare on the next falling edge
    task automatic step(bit r, bit e_n, bit c_n, int a, bit d, string tag);
        rst = r; wr_en_n = e_n; clr_n = c_n; sel = SEL_W'(a); din = d;
        model = ref_next(model, r, e_n, c_n, a, d);
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        @(negedge clk);
        // R6: reset state
        step(1, 1, 1, 0, 0, "R6 reset");
        // R1/R5: set each address, then clear each one
        for (int a = 0; a < N; a++) step(0, 0, 1, a, 1, "R1 R5 write one set");
        for (int a = 0; a < N; a++) step(0, 0, 1, a, 0, "R1 R5 write one clear");
        // R3: a frozen bank ignores data and address
        for (int a = 0; a < N; a++) step(0, 0, 1, a, a[0], "R1 pattern");
        for (int a = 0; a < N; a++) step(0, 1, 1, a, ~a[0], "R3 freeze");
        // R4: wipe mode
        step(0, 1, 0, 3, 1, "R4 wipe");
        // R2/R5: clear-others mode, both polarities
        for (int a = 0; a < N; a++) begin
            step(0, 0, 0, a, 1, "R2 R5 excl d1");
            step(0, 0, 0, a, 0, "R2 R5 excl d0");
        end
        // R8: clear-others then freeze keeps the one-hot pattern
        step(0, 0, 0, 5, 1, "R8 excl");
        step(0, 1, 1, 2, 0, "R8 freeze keep");
        step(0, 1, 1, 7, 1, "R8 freeze keep2");
        // R7: address moves while writing; old bit keeps its last value
        step(0, 0, 1, 1, 1, "R7 write a1");
        step(0, 0, 1, 6, 0, "R7 move a6");
        step(0, 0, 1, 6, 1, "R7 write a6");
        // R9: last sampled write cycle is what the bank holds
        step(0, 0, 1, 4, 1, "R9 write a4");
        step(0, 1, 1, 0, 0, "R9 held");
        step(0, 1, 1, 4, 0, "R9 still held");
        // R6: reset overrides a write request
        step(1, 0, 1, 2, 1, "R6 reset priority");
        step(0, 0, 0, 7, 1, "R2 after reset");
        step(0, 1, 0, 7, 1, "R4 wipe final");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule